// File: doc/BRIEF.md
# Polyphase Scaler Phase Parameter Generator

This block prepares one scaling job for a polyphase video scaler. A single start pulse samples a layer-select mask, the layer's source width and height in unsigned 16.16 fixed point, and the destination width and height in whole pixels. When exactly one layer is selected, it derives six quantities one after another on a single shared sequential divider: a U16.16 upscale ratio per axis, an initial phase per axis in sixteenths of a pixel, and a 16.16 phase increment per output pixel per axis. It then raises a scale-enable flag and pulses done. A detail-enhancer enable follows from the ratios.

A mask with no bit set turns scaling off. A mask with several bits set, or a selected layer with a zero destination dimension, is reported as an error. Once a job has completed, a horizontal phase accumulator walks the source line. It is loaded at each line start and advanced once per output pixel. Its integer part gives the source pixel index and its top four fractional bits give the filter phase.

Top module: `scaler_phase_gen`

## Requirements
- R1: After a successful job, hRatio = floor(dstW * 2^32 / srcW) and vRatio = floor(dstH * 2^32 / srcH), each kept to its low 32 bits (U16.16), with srcW/srcH taken as 16.16 values.
- R2: enhEn is high exactly when scaleEn is high and the integer part (bits 31:16) of hRatio or of vRatio is 2 or more.
- R3: With inX = srcW[31:16] and inY = srcH[31:16], hInit = (floor(inX*16/dstW) + 1) / 2 (integer division) and vInit is the same with inY and dstH.
- R4: hDelta = floor(inX * 65536 / dstW) and vDelta = floor(inY * 65536 / dstH), each kept to 32 bits.
- R5: A start with two or more bits set in layerMask sets err, clears scaleEn and every result output to zero, and pulses done without starting a division.
- R6: A start with layerMask all zero clears err, scaleEn and every result output to zero, and pulses done without starting a division. This applies even when a destination dimension is zero.
- R7: A start with exactly one mask bit set and dstW or dstH equal to zero is treated as in R5.
- R8: done is a one-cycle pulse that follows each accepted start. busy is high from the cycle after an accepted division job starts until done, and scaleEn stays low while busy. A start while busy is ignored: it produces no extra done pulse and does not change any result.
- R9: With scaleEn high, lineStart loads the accumulator with hInit * 4096. srcIdx is accumulator bits 31:16 and filtPhase is accumulator bits 15:12.
- R10: With scaleEn high, pixStep without lineStart adds hDelta to the accumulator, with wrap at 32 bits. When both arrive together, lineStart wins. With scaleEn low, both are ignored and srcIdx/filtPhase stay zero.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (one-cycle pulse) |
| layerMask | input | LAYERS | One bit per layer asking for scaling |
| srcW | input | SRC_W | Source width, unsigned 16.16 |
| srcH | input | SRC_W | Source height, unsigned 16.16 |
| dstW | input | DST_W | Destination width in pixels |
| dstH | input | DST_W | Destination height in pixels |
| lineStart | input | 1 | Reload the phase accumulator |
| pixStep | input | 1 | Advance the accumulator by one output pixel |
| busy | output | 1 | Divisions in progress |
| done | output | 1 | One-cycle job completion pulse |
| err | output | 1 | Last job was rejected |
| scaleEn | output | 1 | Valid scaling parameters are held |
| enhEn | output | 1 | Detail enhancer enable |
| hRatio | output | 32 | Horizontal upscale ratio, U16.16 |
| vRatio | output | 32 | Vertical upscale ratio, U16.16 |
| hInit | output | 32 | Horizontal initial phase, 1/16 pixel units |
| vInit | output | 32 | Vertical initial phase, 1/16 pixel units |
| hDelta | output | 32 | Horizontal phase increment, 16.16 |
| vDelta | output | 32 | Vertical phase increment, 16.16 |
| srcIdx | output | 16 | Current source pixel index |
| filtPhase | output | 4 | Current filter phase |

## Verification
The bench places ratios on both sides of the enhancer threshold (exactly 2.0 and just below it) and uses a fractional source size that an integer-only datapath would divide wrongly. It also uses downscales, where a wrong operand order in the shared divider would swap or corrupt the results. Masks with two bits set, an empty mask and a zero destination height check that rejected jobs clear the results rather than keeping stale values. A second start issued mid-job must leave both the results and the done count untouched. A per-clock model of the accumulator catches a wrong load scaling, a lost lineStart priority, or stepping while scaling is off.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic [2:0] {
    OP_HRATIO = 3'd0,
    OP_VRATIO = 3'd1,
    OP_HINIT  = 3'd2,
    OP_HDELTA = 3'd3,
    OP_VINIT  = 3'd4,
    OP_VDELTA = 3'd5
  } opSel_e;

  typedef struct packed {
    logic   latchIn;
    logic   divGo;
    logic   store;
    logic   setScale;
    logic   clrAll;
    opSel_e op;
  } ctrlStrobe_t;
endpackage

// File: rtl/scl_divider.sv
module scl_divider #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         finished
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     q;
  logic [W:0]       rem;
  logic [W-1:0]     dsr;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [W:0]       shifted;
  logic [W:0]       nextRem;
  logic             qBit;

  always_comb begin
    shifted = {rem[W-1:0], q[W-1]};
    if (shifted >= {1'b0, dsr}) begin
      nextRem = shifted - {1'b0, dsr};
      qBit    = 1'b1;
    end else begin
      nextRem = shifted;
      qBit    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      q        <= '0;
      rem      <= '0;
      dsr      <= '0;
      cnt      <= '0;
      run      <= 1'b0;
      finished <= 1'b0;
    end else begin
      finished <= 1'b0;
      if (go) begin
        q   <= dividend;
        rem <= '0;
        dsr <= divisor;
        cnt <= CNT_W'(W);
        run <= 1'b1;
      end else if (run) begin
        q   <= {q[W-2:0], qBit};
        rem <= nextRem;
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run      <= 1'b0;
          finished <= 1'b1;
        end
      end
    end
  end

  assign quotient = q;
endmodule

// File: rtl/scl_ctrl.sv
module scl_ctrl
  import scl_pkg::*;
#(
  parameter int LAYERS = 4,
  parameter int DST_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LAYERS-1:0] layerMask,
  input  logic [DST_W-1:0]  dstW,
  input  logic [DST_W-1:0]  dstH,
  input  logic              divDone,
  output ctrlStrobe_t       strb,
  output logic              busy,
  output logic              done,
  output logic              err
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} state_e;

  state_e state;
  opSel_e step;
  logic   multiSel;
  logic   noneSel;
  logic   zeroOut;
  logic   reject;

  assign multiSel = |(layerMask & (layerMask - 1'b1));
  assign noneSel  = (layerMask == '0);
  assign zeroOut  = (dstW == '0) || (dstH == '0);
  assign reject   = multiSel || (!noneSel && zeroOut);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strb    = '0;
    strb.op = step;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (reject || noneSel) strb.clrAll  = 1'b1;
          else                   strb.latchIn = 1'b1;
        end
      end
      ST_ISSUE: strb.divGo = 1'b1;
      ST_WAIT: begin
        if (divDone) begin
          strb.store    = 1'b1;
          strb.setScale = (step == OP_VDELTA);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      step  <= OP_HRATIO;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (reject || noneSel) begin
              done <= 1'b1;
              err  <= reject;
            end else begin
              err   <= 1'b0;
              step  <= OP_HRATIO;
              state <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (divDone) begin
            if (step == OP_VDELTA) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              step  <= opSel_e'(step + 3'd1);
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scl_datapath.sv
module scl_datapath
  import scl_pkg::*;
#(
  parameter int DST_W   = 16,
  parameter int SRC_W   = 32,
  parameter int ENH_MIN = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strb,
  input  logic [SRC_W-1:0]         srcW,
  input  logic [SRC_W-1:0]         srcH,
  input  logic [DST_W-1:0]         dstW,
  input  logic [DST_W-1:0]         dstH,
  input  logic                     lineStart,
  input  logic                     pixStep,
  output logic                     divDone,
  output logic                     scaleEn,
  output logic                     enhEn,
  output logic [31:0]              hRatio,
  output logic [31:0]              vRatio,
  output logic [31:0]              hInit,
  output logic [31:0]              vInit,
  output logic [31:0]              hDelta,
  output logic [31:0]              vDelta,
  output logic [31-16:0]           srcIdx,
  output logic [3:0]               filtPhase
);
  localparam int FRAC     = 16;
  localparam int PH_BITS  = 4;
  localparam int PH_SHIFT = FRAC - PH_BITS;
  localparam int RAT_W    = 32;
  localparam int INT_W    = SRC_W - FRAC;
  localparam int DIV_W    = DST_W + 32;

  logic [SRC_W-1:0] sW, sH;
  logic [DST_W-1:0] dW, dH;
  logic [INT_W-1:0] inW, inH;
  logic [DIV_W-1:0] opDividend, opDivisor, quo;
  logic [RAT_W:0]   roundQ;
  logic [RAT_W-1:0] acc;

  assign inW = sW[SRC_W-1:FRAC];
  assign inH = sH[SRC_W-1:FRAC];

  always_comb begin
    case (strb.op)
      OP_HRATIO: begin
        opDividend = {dW, 32'b0};
        opDivisor  = {{(DIV_W-SRC_W){1'b0}}, sW};
      end
      OP_VRATIO: begin
        opDividend = {dH, 32'b0};
        opDivisor  = {{(DIV_W-SRC_W){1'b0}}, sH};
      end
      OP_HINIT: begin
        opDividend = {{(DIV_W-INT_W-PH_BITS){1'b0}}, inW, {PH_BITS{1'b0}}};
        opDivisor  = {{(DIV_W-DST_W){1'b0}}, dW};
      end
      OP_HDELTA: begin
        opDividend = {{(DIV_W-INT_W-FRAC){1'b0}}, inW, {FRAC{1'b0}}};
        opDivisor  = {{(DIV_W-DST_W){1'b0}}, dW};
      end
      OP_VINIT: begin
        opDividend = {{(DIV_W-INT_W-PH_BITS){1'b0}}, inH, {PH_BITS{1'b0}}};
        opDivisor  = {{(DIV_W-DST_W){1'b0}}, dH};
      end
      default: begin
        opDividend = {{(DIV_W-INT_W-FRAC){1'b0}}, inH, {FRAC{1'b0}}};
        opDivisor  = {{(DIV_W-DST_W){1'b0}}, dH};
      end
    endcase
  end

  scl_divider #(.W(DIV_W)) uDiv (
    .clk      (clk),
    .rstN     (rstN),
    .go       (strb.divGo),
    .dividend (opDividend),
    .divisor  (opDivisor),
    .quotient (quo),
    .finished (divDone)
  );

  assign roundQ = {1'b0, quo[RAT_W-1:0]} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sW <= '0; sH <= '0; dW <= '0; dH <= '0;
    end else if (strb.latchIn) begin
      sW <= srcW; sH <= srcH; dW <= dstW; dH <= dstH;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrAll || strb.latchIn) begin
      hRatio  <= '0; vRatio <= '0;
      hInit   <= '0; vInit  <= '0;
      hDelta  <= '0; vDelta <= '0;
      scaleEn <= 1'b0;
    end else begin
      if (strb.store) begin
        case (strb.op)
          OP_HRATIO: hRatio <= quo[RAT_W-1:0];
          OP_VRATIO: vRatio <= quo[RAT_W-1:0];
          OP_HINIT:  hInit  <= roundQ[RAT_W:1];
          OP_HDELTA: hDelta <= quo[RAT_W-1:0];
          OP_VINIT:  vInit  <= roundQ[RAT_W:1];
          default:   vDelta <= quo[RAT_W-1:0];
        endcase
      end
      if (strb.setScale) scaleEn <= 1'b1;
    end
  end

  assign enhEn = scaleEn &&
                 ((hRatio[RAT_W-1:FRAC] >= (RAT_W-FRAC)'(ENH_MIN)) ||
                  (vRatio[RAT_W-1:FRAC] >= (RAT_W-FRAC)'(ENH_MIN)));

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrAll || strb.latchIn) begin
      acc <= '0;
    end else if (scaleEn) begin
      if (lineStart)    acc <= hInit << PH_SHIFT;
      else if (pixStep) acc <= acc + hDelta;
    end
  end

  assign srcIdx    = acc[RAT_W-1:FRAC];
  assign filtPhase = acc[FRAC-1 -: PH_BITS];
endmodule

// File: rtl/scaler_phase_gen.sv
module scaler_phase_gen
  import scl_pkg::*;
#(
  parameter int LAYERS = 4,
  parameter int DST_W  = 16,
  parameter int SRC_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LAYERS-1:0] layerMask,
  input  logic [SRC_W-1:0]  srcW,
  input  logic [SRC_W-1:0]  srcH,
  input  logic [DST_W-1:0]  dstW,
  input  logic [DST_W-1:0]  dstH,
  input  logic              lineStart,
  input  logic              pixStep,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              scaleEn,
  output logic              enhEn,
  output logic [31:0]       hRatio,
  output logic [31:0]       vRatio,
  output logic [31:0]       hInit,
  output logic [31:0]       vInit,
  output logic [31:0]       hDelta,
  output logic [31:0]       vDelta,
  output logic [15:0]       srcIdx,
  output logic [3:0]        filtPhase
);
  ctrlStrobe_t strb;
  logic        divDone;

  scl_ctrl #(.LAYERS(LAYERS), .DST_W(DST_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .layerMask (layerMask),
    .dstW      (dstW),
    .dstH      (dstH),
    .divDone   (divDone),
    .strb      (strb),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  scl_datapath #(.DST_W(DST_W), .SRC_W(SRC_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .srcW      (srcW),
    .srcH      (srcH),
    .dstW      (dstW),
    .dstH      (dstH),
    .lineStart (lineStart),
    .pixStep   (pixStep),
    .divDone   (divDone),
    .scaleEn   (scaleEn),
    .enhEn     (enhEn),
    .hRatio    (hRatio),
    .vRatio    (vRatio),
    .hInit     (hInit),
    .vInit     (vInit),
    .hDelta    (hDelta),
    .vDelta    (vDelta),
    .srcIdx    (srcIdx),
    .filtPhase (filtPhase)
  );
endmodule

// File: rtl/scaler_phase_gen_chk.sv
module scaler_phase_gen_chk #(
  parameter int LAYERS = 4,
  parameter int DST_W  = 16,
  parameter int SRC_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [LAYERS-1:0] layerMask,
  input logic              lineStart,
  input logic              pixStep,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              scaleEn,
  input logic              enhEn,
  input logic [31:0]       hRatio,
  input logic [31:0]       vRatio,
  input logic [15:0]       srcIdx,
  input logic [3:0]        filtPhase
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R8

  AST_NO_SCALE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !scaleEn);  // R8

  AST_ERR_NO_SCALE: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!scaleEn && hRatio == 32'd0 && vRatio == 32'd0));  // R5

  AST_ENH_NEEDS_SCALE: assert property (@(posedge clk) disable iff (!rstN)
    enhEn |-> scaleEn);  // R2

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!lineStart && !pixStep && !busy && !start) |=> $stable({srcIdx, filtPhase}));  // R10

  AST_NO_SCALE_ACC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!scaleEn && !busy) |-> (srcIdx == 16'd0 && filtPhase == 4'd0));  // R10
endmodule

bind scaler_phase_gen scaler_phase_gen_chk #(.LAYERS(LAYERS), .DST_W(DST_W), .SRC_W(SRC_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .layerMask (layerMask),
  .lineStart (lineStart),
  .pixStep   (pixStep),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .scaleEn   (scaleEn),
  .enhEn     (enhEn),
  .hRatio    (hRatio),
  .vRatio    (vRatio),
  .srcIdx    (srcIdx),
  .filtPhase (filtPhase)
);

// File: tb/scaler_phase_gen_test.sv
`timescale 1ns/1ps
module scaler_phase_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  layerMask = '0;
  logic [31:0] srcW = '0, srcH = '0;
  logic [15:0] dstW = '0, dstH = '0;
  logic        lineStart = 1'b0, pixStep = 1'b0;
  logic        busy, done, err, scaleEn, enhEn;
  logic [31:0] hRatio, vRatio, hInit, vInit, hDelta, vDelta;
  logic [15:0] srcIdx;
  logic [3:0]  filtPhase;

  int checks = 0;
  int fails  = 0;
  bit finishedRun = 0;
  int doneCount = 0;

  longint expHInit = 0, expHDelta = 0;
  longint modelAcc = 0;
  bit     modelValid = 0;

  always #10 clk = ~clk;

  scaler_phase_gen uut (
    .clk(clk), .rstN(rstN), .start(start), .layerMask(layerMask),
    .srcW(srcW), .srcH(srcH), .dstW(dstW), .dstH(dstH),
    .lineStart(lineStart), .pixStep(pixStep),
    .busy(busy), .done(done), .err(err), .scaleEn(scaleEn), .enhEn(enhEn),
    .hRatio(hRatio), .vRatio(vRatio), .hInit(hInit), .vInit(vInit),
    .hDelta(hDelta), .vDelta(vDelta), .srcIdx(srcIdx), .filtPhase(filtPhase)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint refRatio(input longint dst, input longint src);
    if (src == 0) return 64'hFFFFFFFF;
    return ((dst << 32) / src) & 64'hFFFFFFFF;
  endfunction
  function automatic longint refInit(input longint src, input longint dst);
    longint inPx = src >> 16;
    return ((inPx * 16) / dst + 1) / 2;
  endfunction
  function automatic longint refDelta(input longint src, input longint dst);
    longint inPx = src >> 16;
    return ((inPx * 65536) / dst) & 64'hFFFFFFFF;
  endfunction

  // Per-clock accumulator model (R9, R10)
  always @(posedge clk) begin
    if (modelValid) begin
      if (lineStart)    modelAcc = (expHInit * 4096) & 64'hFFFFFFFF;
      else if (pixStep) modelAcc = (modelAcc + expHDelta) & 64'hFFFFFFFF;
    end
    if (done) doneCount++;
  end

  always @(negedge clk) begin
    if (rstN && modelValid) begin
      chk(longint'(srcIdx) == ((modelAcc >> 16) & 64'hFFFF), "R9/R10 srcIdx",
          longint'(srcIdx), (modelAcc >> 16) & 64'hFFFF);
      chk(longint'(filtPhase) == ((modelAcc >> 12) & 64'hF), "R9/R10 filtPhase",
          longint'(filtPhase), (modelAcc >> 12) & 64'hF);
    end
  end

  task automatic pulseStart(input logic [3:0] m, input longint sw, input longint sh,
                            input longint dw, input longint dh);
    @(negedge clk);
    layerMask = m;
    srcW = sw[31:0]; srcH = sh[31:0];
    dstW = dw[15:0]; dstH = dh[15:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output bit seen);
    seen = 0;
    for (int i = 0; i < 1000; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic runGood(input string tag, input longint sw, input longint sh,
                         input longint dw, input longint dh);
    bit seen;
    longint eHR, eVR;
    modelValid = 0;
    pulseStart(4'b0100, sw, sh, dw, dh);
    chk(busy == 1'b1, {tag, " R8 busy"}, longint'(busy), 1);
    waitDone(seen);
    chk(seen, {tag, " R8 done"}, longint'(seen), 1);
    eHR = refRatio(dw, sw);
    eVR = refRatio(dh, sh);
    chk(longint'(hRatio) == eHR, {tag, " R1 hRatio"}, longint'(hRatio), eHR);
    chk(longint'(vRatio) == eVR, {tag, " R1 vRatio"}, longint'(vRatio), eVR);
    chk(longint'(hInit) == refInit(sw, dw), {tag, " R3 hInit"}, longint'(hInit), refInit(sw, dw));
    chk(longint'(vInit) == refInit(sh, dh), {tag, " R3 vInit"}, longint'(vInit), refInit(sh, dh));
    chk(longint'(hDelta) == refDelta(sw, dw), {tag, " R4 hDelta"}, longint'(hDelta), refDelta(sw, dw));
    chk(longint'(vDelta) == refDelta(sh, dh), {tag, " R4 vDelta"}, longint'(vDelta), refDelta(sh, dh));
    chk(scaleEn == 1'b1 && err == 1'b0, {tag, " R8 scaleEn"}, longint'(scaleEn), 1);
    chk(longint'(enhEn) == longint'((eHR >> 16) >= 2 || (eVR >> 16) >= 2),
        {tag, " R2 enhEn"}, longint'(enhEn), longint'((eHR >> 16) >= 2 || (eVR >> 16) >= 2));
    expHInit  = refInit(sw, dw);
    expHDelta = refDelta(sw, dw);
    modelAcc  = 0;
    modelValid = 1;
  endtask

  task automatic runReject(input string tag, input logic [3:0] m, input longint dw,
                           input longint dh, input bit expErr);
    bit seen;
    modelValid = 0;
    pulseStart(m, 64'd100 << 16, 64'd100 << 16, dw, dh);
    chk(busy == 1'b0, {tag, " busy stays low"}, longint'(busy), 0);
    waitDone(seen);
    chk(seen, {tag, " done"}, longint'(seen), 1);
    chk(longint'(err) == longint'(expErr), {tag, " err"}, longint'(err), longint'(expErr));
    chk(scaleEn == 1'b0 && enhEn == 1'b0, {tag, " scaleEn cleared"}, longint'(scaleEn), 0);
    chk(hRatio == 0 && vRatio == 0 && hInit == 0 && vInit == 0 && hDelta == 0 && vDelta == 0,
        {tag, " results cleared"}, longint'(hRatio), 0);
  endtask

  task automatic stepPix(input int n, input bit withLine);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pixStep = 1'b1;
      lineStart = withLine && (i == 0);
    end
    @(negedge clk);
    pixStep = 1'b0;
    lineStart = 1'b0;
  endtask

  task automatic finishRun();
    if (!finishedRun) begin
      finishedRun = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finishRun();
  end

  initial begin
    int cnt0;
    bit seen;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy == 0 && done == 0 && err == 0 && scaleEn == 0 && enhEn == 0, "R11 flags",
        longint'({busy, done, err, scaleEn, enhEn}), 0);
    chk(hRatio == 0 && vRatio == 0 && hInit == 0 && hDelta == 0 && srcIdx == 0 && filtPhase == 0,
        "R11 values", longint'(hRatio), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Upscale 2.5x horizontal, 1.2x vertical
    runGood("A", 64'd100 << 16, 64'd100 << 16, 250, 120);
    // R9: line start load then pixel steps
    @(negedge clk); lineStart = 1'b1;
    @(negedge clk); lineStart = 1'b0;
    stepPix(20, 0);
    // R10: lineStart and pixStep together, lineStart wins
    stepPix(5, 1);
    repeat (3) @(negedge clk);

    // Exactly 2.0 on horizontal: enhancer boundary (R2)
    runGood("B", 64'd100 << 16, 64'd100 << 16, 200, 100);
    // Just below 2.0 on both axes (R2)
    runGood("C", 64'd100 << 16, 64'd100 << 16, 199, 199);
    // Vertical only crosses 2.0 (R2)
    runGood("D", 64'd64 << 16, 64'd30 << 16, 64, 90);
    // Downscale both axes
    runGood("E", 64'd640 << 16, 64'd480 << 16, 320, 240);
    @(negedge clk); lineStart = 1'b1;
    @(negedge clk); lineStart = 1'b0;
    stepPix(40, 0);
    // Fractional source size
    runGood("F", (64'd100 << 16) + 64'd32768, (64'd37 << 16) + 64'd12345, 301, 111);
    stepPix(10, 1);

    // R5: two mask bits
    runReject("R5 multi", 4'b0110, 200, 200, 1);
    // R10: steps ignored while scaling off
    @(negedge clk); lineStart = 1'b1; pixStep = 1'b1;
    @(negedge clk); lineStart = 1'b0;
    @(negedge clk); pixStep = 1'b0;
    @(negedge clk);
    chk(srcIdx == 0 && filtPhase == 0, "R10 ignored when disabled", longint'(srcIdx), 0);
    // R6: empty mask, also with zero dest
    runReject("R6 none", 4'b0000, 200, 200, 0);
    runReject("R6 none zero", 4'b0000, 0, 0, 0);
    // R7: zero destination height / width
    runReject("R7 zero dstH", 4'b0001, 200, 0, 1);
    runReject("R7 zero dstW", 4'b1000, 0, 50, 1);

    // R8: start while busy is ignored
    modelValid = 0;
    pulseStart(4'b0001, 64'd50 << 16, 64'd40 << 16, 150, 100);
    repeat (10) @(negedge clk);
    cnt0 = doneCount;
    start = 1'b1; layerMask = 4'b0011; srcW = 32'd7 << 16; dstW = 16'd3;
    @(negedge clk);
    start = 1'b0;
    waitDone(seen);
    @(negedge clk);
    chk(longint'(hRatio) == refRatio(150, 64'd50 << 16), "R8 busy start ignored hRatio",
        longint'(hRatio), refRatio(150, 64'd50 << 16));
    chk(longint'(hDelta) == refDelta(64'd50 << 16, 150), "R8 busy start ignored hDelta",
        longint'(hDelta), refDelta(64'd50 << 16, 150));
    chk(err == 1'b0 && scaleEn == 1'b1, "R8 busy start no error", longint'(err), 0);
    repeat (400) @(negedge clk);
    chk(doneCount - cnt0 == 1, "R8 single done", longint'(doneCount - cnt0), 1);

    finishRun();
  end
endmodule